// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block gates a bank of clock outputs derived from one source clock in response to an active-low stop request that may arrive at any time, with no relation to that clock. The request passes through a synchronizer in the source clock domain. A run controller decides when the gated outputs may halt and when they may resume. A gating stage then lets the source clock through or holds each output low. The gate decision is taken on the falling edge of the source, so an output never shows a shortened high phase. A stopped output always rests low, and a restarted output begins with a complete high phase.

Each group of clocks gets its own instance, with its own synchronizer depth and its own minimum run length. A fast processor group might use two synchronizer stages and a run of 100 cycles, while a slower bus group might use one stage and a run of 10 cycles. The stop request is honoured only when the mode strap selects mobile operation; in desktop mode it is ignored. Every output has its own enable bit, which can hold it low, and a global tristate input overrides all of them. Outputs named in a free-run mask are not affected by the stop request.

Top module: `clkstop_ctrl`

## Requirements
- R1: An output that is stopped or disabled stays low for the whole period. Every high phase an output shows lasts the full high phase of the source clock, with no runt pulse on either stop or restart.
- R2: In mobile mode (`desk_mode` = 0), when `stop_req_n` falls, each gated output delivers exactly SYNC_STAGES+1 more high phases and then stays low: 3 with two stages, 2 with one stage.
- R3: When `stop_req_n` rises on a stopped group, the outputs stay low for the next SYNC_STAGES+1 rising edges of the source. They then resume on rising edge SYNC_STAGES+2.
- R4: In desktop mode (`desk_mode` = 1), `stop_req_n` has no effect and the outputs keep running.
- R5: Once a group has started, it delivers at least MIN_RUN+1 high phases before it stops again, even if the stop request returns at once. A short release gives exactly MIN_RUN+1 high phases.
- R6: Bit i of `reg_en` at 0 holds `clk_out[i]` low, whatever the stop request. At 1, the bit lets the output follow the run state.
- R7: While `hiz` = 1, `clk_oe` = 0 and every `clk_out` bit is 0, overriding the enables and the stop request. With `hiz` = 0, `clk_oe` = 1.
- R8: An output whose bit is set in FREE_MASK ignores the stop request and obeys only its `reg_en` bit and `hiz`.
- R9: While `rst_n` is low, all outputs are low. The block leaves reset in the running state, and the minimum run count starts from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| desk_mode | input | 1 | Latched mode strap: 0 mobile (stop honoured), 1 desktop |
| hiz | input | 1 | Global tristate: forces outputs off and drops the output enable |
| reg_en | input | N | Per-output enable, 1 = may run |
| clk_out | output | N | Gated clock outputs |
| clk_oe | output | 1 | Output driver enable, 0 while tristated |

## Verification
Some properties are checked on every cycle. A stop of the run state must follow a synchronized request seen in mobile mode, after the minimum run count. A synchronized release must restart the group on the next cycle. Free-running outputs must stay enabled while their enable bit holds, and the tristate input must silence the outputs.

Other behaviour needs the bench scenarios. These include the exact number of high phases after a stop or a release, the absence of runt pulses and of high levels during the low phase, and the exact run length after a short release. Each is measured by sampling the outputs twice per high phase and once per low phase, for two instances with different synchronizer depths.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic {
    STRAP_MOBILE  = 1'b0,
    STRAP_DESKTOP = 1'b1
  } strap_e;

  // A synchronized request only counts in mobile mode.
  function automatic logic stop_honoured(input logic desk, input logic seen);
    return (strap_e'(desk) == STRAP_MOBILE) && seen;
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic stop_seen
);
  logic [STAGES-1:0] sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq <= '1;
    end else begin
      sq[0] <= req_n;
      for (int i = 1; i < STAGES; i++) sq[i] <= sq[i-1];
    end
  end

  assign stop_seen = ~sq[STAGES-1];
endmodule

// File: rtl/clkstop_runctl.sv
module clkstop_runctl #(
  parameter int MIN_RUN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic desk_mode,
  input  logic stop_seen,
  output logic run_on,
  output logic min_ok
);
  localparam int CW = $clog2(MIN_RUN + 1);

  logic [CW-1:0] cnt_q;
  logic          hon;

  function automatic logic [CW-1:0] cnt_step(input logic [CW-1:0] c);
    return (c >= CW'(MIN_RUN)) ? c : c + 1'b1;
  endfunction

  function automatic logic reached(input logic [CW-1:0] c);
    return c >= CW'(MIN_RUN);
  endfunction

  assign hon    = clkstop_pkg::stop_honoured(desk_mode, stop_seen);
  assign min_ok = reached(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_on <= 1'b1;
      cnt_q  <= '0;
    end else if (run_on) begin
      if (hon && min_ok) run_on <= 1'b0;
      else               cnt_q  <= cnt_step(cnt_q);
    end else if (!hon) begin
      run_on <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int             N         = 3,
  parameter logic [N-1:0]   FREE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_on,
  input  logic         hiz,
  input  logic [N-1:0] reg_en,
  output logic [N-1:0] gate_on,
  output logic [N-1:0] clk_out
);
  logic [N-1:0] gate_d;

  for (genvar i = 0; i < N; i++) begin : g_out
    if (FREE_MASK[i]) begin : g_free
      assign gate_d[i] = reg_en[i];
    end else begin : g_stop
      assign gate_d[i] = reg_en[i] & run_on;
    end
    assign clk_out[i] = clk & gate_on[i] & ~hiz;
  end

  // Enable changes only on the falling edge, while the source is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_on <= '0;
    else        gate_on <= gate_d;
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int           N           = 3,
  parameter int           SYNC_STAGES = 2,
  parameter int           MIN_RUN     = 100,
  parameter logic [N-1:0] FREE_MASK   = '0
) (
  input  logic         clk_src,
  input  logic         rst_n,
  input  logic         stop_req_n,
  input  logic         desk_mode,
  input  logic         hiz,
  input  logic [N-1:0] reg_en,
  output logic [N-1:0] clk_out,
  output logic         clk_oe
);
  logic         stop_seen;
  logic         run_on;
  logic         min_ok;
  logic [N-1:0] gate_on;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_src), .rst_n(rst_n), .req_n(stop_req_n), .stop_seen(stop_seen)
  );

  clkstop_runctl #(.MIN_RUN(MIN_RUN)) u_run (
    .clk(clk_src), .rst_n(rst_n), .desk_mode(desk_mode),
    .stop_seen(stop_seen), .run_on(run_on), .min_ok(min_ok)
  );

  clkstop_gate #(.N(N), .FREE_MASK(FREE_MASK)) u_gate (
    .clk(clk_src), .rst_n(rst_n), .run_on(run_on), .hiz(hiz),
    .reg_en(reg_en), .gate_on(gate_on), .clk_out(clk_out)
  );

  assign clk_oe = ~hiz;
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int           N         = 3,
  parameter int           MIN_RUN   = 100,
  parameter logic [N-1:0] FREE_MASK = '0
) (
  input logic         clk_src,
  input logic         rst_n,
  input logic         desk_mode,
  input logic         hiz,
  input logic [N-1:0] reg_en,
  input logic [N-1:0] clk_out,
  input logic         clk_oe,
  input logic         stop_seen,
  input logic         run_on,
  input logic         min_ok,
  input logic [N-1:0] gate_on
);
  int unsigned run_len;
  logic [1:0]  age;
  logic        started;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
      age     <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (!run_on)                       run_len <= 0;
      else if (run_len <= MIN_RUN)       run_len <= run_len + 1;
    end
  end
  assign started = (age == 2'd3);

  // R4: a stop happens only when mobile mode was selected
  p_desktop_keeps_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(run_on) |-> !$past(desk_mode)) else $error("R4 stop in desktop mode");

  // R2: a stop needs a synchronized request and the run window complete
  p_stop_cause_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(run_on) |-> ($past(stop_seen) && $past(min_ok))) else $error("R2 stop without cause");

  // R5: independent run length counter
  p_min_run_r5: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(run_on) |-> (run_len >= MIN_RUN)) else $error("R5 run too short");

  // R3: released request restarts on the next cycle
  p_restart_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!run_on && !stop_seen) |=> run_on) else $error("R3 no restart");

  // R7: tristate silences outputs during the high phase
  p_tristate_r7: assert property (@(negedge clk_src) disable iff (!rst_n)
    hiz |-> (!clk_oe && clk_out == '0)) else $error("R7 outputs active in tristate");

  for (genvar i = 0; i < N; i++) begin : g_chk
    if (FREE_MASK[i]) begin : g_free
      // R8: free outputs stay enabled while their enable bit holds
      p_free_run_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
        (started && reg_en[i] && $past(reg_en[i])) |-> gate_on[i])
        else $error("R8 free output gated");
    end
  end
endmodule

bind clkstop_ctrl clkstop_chk #(.N(N), .MIN_RUN(MIN_RUN), .FREE_MASK(FREE_MASK)) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .desk_mode(desk_mode), .hiz(hiz),
  .reg_en(reg_en), .clk_out(clk_out), .clk_oe(clk_oe), .stop_seen(stop_seen),
  .run_on(run_on), .min_ok(min_ok), .gate_on(gate_on)
);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/100ps
module clkstop_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_n = 1'b1;
  logic       desk = 1'b1;
  logic       hiz = 1'b0;
  logic [2:0] en = 3'b111;
  logic [2:0] dout;
  logic       doe;
  logic [0:0] pout;
  logic       poe;

  int nchk = 0;
  int nerr = 0;
  int pc0 = 0, pc1 = 0, pc2 = 0, pcp = 0;
  int runt = 0, lowerr = 0;

  always #2.5 clk = ~clk;

  clkstop_ctrl #(.N(3), .SYNC_STAGES(2), .MIN_RUN(12), .FREE_MASK(3'b100)) u_dut (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_n), .desk_mode(desk),
    .hiz(hiz), .reg_en(en), .clk_out(dout), .clk_oe(doe)
  );

  clkstop_ctrl #(.N(1), .SYNC_STAGES(1), .MIN_RUN(4), .FREE_MASK(1'b0)) u_dut_pci (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_n), .desk_mode(desk),
    .hiz(hiz), .reg_en(en[0:0]), .clk_out(pout), .clk_oe(poe)
  );

  // Two samples per high phase: full pulse counts, partial is a runt (R1).
  always @(posedge clk) begin
    logic [3:0] a, b;
    #0.8 a = {pout, dout};
    #1.0 b = {pout, dout};
    if (a[0] && b[0]) pc0++;
    if (a[1] && b[1]) pc1++;
    if (a[2] && b[2]) pc2++;
    if (a[3] && b[3]) pcp++;
    if (a != b) runt++;
  end

  // Low phase must be low on every output (R1).
  always @(negedge clk) begin
    #1;
    if (dout != 3'b000 || pout != 1'b0) lowerr++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic win(input int n, output int d0, output int d1, output int d2, output int dp);
    int s0, s1, s2, sp;
    s0 = pc0; s1 = pc1; s2 = pc2; sp = pcp;
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
    d0 = pc0 - s0; d1 = pc1 - s1; d2 = pc2 - s2; dp = pcp - sp;
  endtask

  // {desk, en[2:0], hiz, stop_n, exp0, exp1, exp2, exp_oe}
  localparam logic [18:0] TBL [8] = '{
    {1'b1, 3'b111, 1'b0, 1'b1, 4'd10, 4'd10, 4'd10, 1'b1},
    {1'b1, 3'b111, 1'b0, 1'b0, 4'd10, 4'd10, 4'd10, 1'b1},
    {1'b0, 3'b111, 1'b0, 1'b0, 4'd0,  4'd0,  4'd10, 1'b1},
    {1'b0, 3'b111, 1'b0, 1'b1, 4'd10, 4'd10, 4'd10, 1'b1},
    {1'b0, 3'b010, 1'b0, 1'b1, 4'd0,  4'd10, 4'd0,  1'b1},
    {1'b0, 3'b011, 1'b0, 1'b0, 4'd0,  4'd0,  4'd0,  1'b1},
    {1'b0, 3'b111, 1'b1, 1'b1, 4'd0,  4'd0,  4'd0,  1'b0},
    {1'b1, 3'b101, 1'b0, 1'b0, 4'd10, 4'd0,  4'd10, 1'b1}
  };

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int d0, d1, d2, dp, a0, ap;
    @(negedge clk); #1;
    // R9: outputs low during reset
    win(5, d0, d1, d2, dp);
    chk("R9 reset pulses", d0 + d1 + d2 + dp, 0);
    chk("R9 reset oe", int'(doe), 1);
    rst_n = 1'b1;

    // Table: rows cover R2 R3 R4 R6 R7 R8
    for (int r = 0; r < 8; r++) begin
      desk = TBL[r][18]; en = TBL[r][17:15]; hiz = TBL[r][14]; stop_n = TBL[r][13];
      win(30, d0, d1, d2, dp);
      win(10, d0, d1, d2, dp);
      chk($sformatf("R2 R4 R6 R7 R8 row %0d out0", r), d0, int'(TBL[r][12:9]));
      chk($sformatf("R2 R4 R6 R7 R8 row %0d out1", r), d1, int'(TBL[r][8:5]));
      chk($sformatf("R3 R6 R7 R8 row %0d out2", r), d2, int'(TBL[r][4:1]));
      chk($sformatf("R7 row %0d oe", r), int'(doe), int'(TBL[r][0]));
    end

    // Stop latency per synchronizer depth (R2), free output keeps going (R8)
    desk = 1'b0; en = 3'b111; hiz = 1'b0; stop_n = 1'b1;
    win(30, d0, d1, d2, dp);
    stop_n = 1'b0;
    win(8, d0, d1, d2, dp);
    chk("R2 stop latency two stages", d0, 3);
    chk("R2 stop latency one stage", dp, 2);
    chk("R8 free output during stop", d2, 8);

    // Restart latency (R3)
    stop_n = 1'b1;
    win(4, d0, d1, d2, dp);
    chk("R3 restart two stages", d0, 1);
    chk("R3 restart one stage", dp, 2);

    // Minimum run after a short release (R5)
    stop_n = 1'b0;
    win(40, d0, d1, d2, dp);
    stop_n = 1'b1;
    win(4, a0, d1, d2, ap);
    stop_n = 1'b0;
    win(40, d0, d1, d2, dp);
    chk("R5 min run two stages", a0 + d0, 13);
    chk("R5 min run one stage", ap + dp, 5);

    // R1: no runt pulse and nothing high in a low phase
    chk("R1 runt pulses", runt, 0);
    chk("R1 high in low phase", lowerr, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule